// File: doc/BRIEF.md
# Dual-Mode Scratchpad / Data Cache Array

This block is a single on-chip storage array with two modes, selected by a mode input. In scratchpad mode a request indexes the data array directly: the byte address, shifted down by the line size, names a line slot, and no tag is consulted. In cache mode the same array becomes a set-associative data cache. It keeps its own tag, valid and dirty state. It reports hit or miss on every response, and it fetches or returns whole lines through a simple request/response port to the next memory level.

Requests are word-sized loads or stores. Each request carries a flag that says whether the address lies in the global space or the local space. The two spaces use different write policies. A global store updates the line and then writes the whole line through to the next level, so it never marks the line dirty. A local store only marks the line dirty, and the next level sees the data when the line is evicted or flushed. A lookup compares all the tags of the selected set in one cycle, and then reads the data of the single matching way in the next cycle.

The block has one request in flight at a time. A miss stalls the request interface until the fill completes. Every accepted request gets exactly one response.

Top module: `flex_store`

## Requirements
- R1: In cache mode the address splits into a byte offset within the line (low OFF_W bits, 7 by default for 128-byte lines), a set index (the next SET_W bits, 6 by default for 64 sets) and a tag (the remaining bits, 27 of a 40-bit address by default). A request to a line that is already resident responds with hit=1 and causes no next-level traffic. A request to any other line responds with hit=0.
- R2: Each set holds WAYS lines (8 by default). On a miss the victim is chosen per set in round-robin order, starting at way 0 after reset and advancing by one on every fill of that set.
- R3: A global store (local=0) updates the word and, before it responds, writes the complete line to the next level. It never sets the line's dirty bit.
- R4: A local store (local=1) updates only the array and sets the line's dirty bit. The next level is unchanged until that line is evicted or flushed.
- R5: When the chosen victim is valid and dirty, its full line is written to the next level before the fill read for the new line is issued.
- R6: A load returns the latest value stored to that word, whether the value came from a fill or from an earlier store.
- R7: When the mode input changes from cache to scratchpad, every dirty line is written back and then every tag is invalidated. The first access after the block returns to cache mode therefore misses.
- R8: In scratchpad mode, word W of line slot S is read and written directly with no tag check. No next-level traffic occurs.
- R9: In scratchpad mode, an access to a line slot at or above SP_LINES (384 slots = 48 KiB by default), or with nonzero low address bits inside a word, responds with err=1 and rdata=0 and writes nothing.
- R10: After reset, req_ready=1, rsp_valid=0 and mem_req_valid=0. req_ready stays low from acceptance until the response, and is also low while a mode change is being carried out. Each accepted request yields exactly one single-cycle rsp_valid pulse.
- R11: Once mem_req_valid rises, it is held together with a stable mem_req_addr until the cycle in which mem_rsp_valid is high. Each transfer moves one whole line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | 1 = cache mode, 0 = scratchpad mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle if valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_local | input | 1 | 1 = local space (write-back), 0 = global (write-through) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DW | Store data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW | Load data |
| rsp_hit | output | 1 | Cache-mode hit indication |
| rsp_err | output | 1 | Scratchpad out-of-range or misaligned access |
| mem_req_valid | output | 1 | Next-level request, held until response |
| mem_req_write | output | 1 | 1 = line write, 0 = line read |
| mem_req_addr | output | ADDR_W-OFF_W | Line address |
| mem_req_wdata | output | 8*2^OFF_W | Line write data |
| mem_rsp_valid | input | 1 | Next-level completion strobe |
| mem_rsp_rdata | input | 8*2^OFF_W | Line read data |

## Verification
The bench uses a small geometry so that it can sweep every line of several sets through the whole round-robin cycle. It targets three kinds of bug.

- Wrong victim selection. A victim counter that is shared between sets, or that fails to advance, would report hits where the bench's round-robin model expects misses.
- Write-policy mixups. A design that swaps the two policies would leave next-level memory stale after a global store, or update it too early after a local store. A design that fetches the new line before writing the dirty victim back shows up in the order of the next-level transactions.
- Mode-change errors. A flush that skips the last line, or that fails to invalidate the tags, would show as memory that disagrees with the bench's golden image after the switch, or as a false hit on the first access back in cache mode. Scratchpad accesses at the first out-of-range slot, or at misaligned addresses, must report an error without touching memory.

// File: rtl/flex_store.sv
module flex_store #(
  parameter int ADDR_W   = 40,
  parameter int OFF_W    = 7,
  parameter int SET_W    = 6,
  parameter int WAYS     = 8,
  parameter int SP_LINES = 384,
  parameter int DW       = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cache_en,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic                       req_local,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DW-1:0]              req_wdata,
  output logic                       rsp_valid,
  output logic [DW-1:0]              rsp_rdata,
  output logic                       rsp_hit,
  output logic                       rsp_err,
  output logic                       mem_req_valid,
  output logic                       mem_req_write,
  output logic [ADDR_W-OFF_W-1:0]    mem_req_addr,
  output logic [(8<<OFF_W)-1:0]      mem_req_wdata,
  input  logic                       mem_rsp_valid,
  input  logic [(8<<OFF_W)-1:0]      mem_rsp_rdata
);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int SETS   = 1 << SET_W;
  localparam int LINES  = WAYS * SETS;
  localparam int LINE_W = 8 << OFF_W;
  localparam int BO_W   = $clog2(DW / 8);
  localparam int WD_W   = OFF_W - BO_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int IDX_W  = SET_W + WAY_W;

  typedef enum logic [2:0] {S_IDLE, S_SP, S_LOOK, S_WB, S_FILL, S_ACC, S_WT, S_FLS} st_t;

  st_t               st;
  logic              mode_q, wr_r, loc_r, hit_r, rsp_v_q;
  logic [ADDR_W-1:0] addr_r;
  logic [DW-1:0]     wd_r;
  logic [IDX_W-1:0]  idx_r;
  logic [LINE_W-1:0] data_q [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  vld_q, dty_q;
  logic [WAY_W-1:0]  rr_q   [SETS];

  wire [SET_W-1:0] set_r   = addr_r[OFF_W +: SET_W];
  wire [TAG_W-1:0] tag_r   = addr_r[ADDR_W-1 -: TAG_W];
  wire [WD_W-1:0]  wsel    = addr_r[BO_W +: WD_W];
  wire [LA_W-1:0]  line_r  = addr_r[ADDR_W-1:OFF_W];
  wire             sp_err  = (line_r >= LA_W'(SP_LINES)) || (addr_r[BO_W-1:0] != '0);
  wire [IDX_W-1:0] sp_idx  = line_r[IDX_W-1:0];
  wire [IDX_W-1:0] vic     = {set_r, rr_q[set_r]};
  wire             ln_dty  = vld_q[idx_r] & dty_q[idx_r];

  logic             hit;
  logic [WAY_W-1:0] hway;
  always_comb begin
    hit  = 1'b0;
    hway = '0;
    for (int w = 0; w < WAYS; w++)
      if (vld_q[{set_r, WAY_W'(w)}] && tag_q[{set_r, WAY_W'(w)}] == tag_r) begin
        hit  = 1'b1;
        hway = WAY_W'(w);
      end
  end

  assign req_ready     = (st == S_IDLE) && (cache_en == mode_q) && !rsp_v_q;
  assign rsp_valid     = rsp_v_q;
  assign mem_req_valid = (st == S_WB) || (st == S_FILL) || (st == S_WT) || (st == S_FLS && ln_dty);
  assign mem_req_write = (st != S_FILL);
  assign mem_req_addr  = (st == S_FILL || st == S_WT) ? line_r
                                                      : {tag_q[idx_r], idx_r[IDX_W-1 -: SET_W]};
  assign mem_req_wdata = data_q[idx_r];

  always_ff @(posedge clk) begin
    rsp_v_q <= 1'b0;
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= 1'b1; vld_q <= '0; dty_q <= '0; idx_r <= '0;
      rsp_rdata <= '0; rsp_hit <= 1'b0; rsp_err <= 1'b0; hit_r <= 1'b0;
      wr_r <= 1'b0; loc_r <= 1'b0; addr_r <= '0; wd_r <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (cache_en != mode_q && !rsp_v_q) begin
            if (mode_q) begin st <= S_FLS; idx_r <= '0; end
            else mode_q <= 1'b1;
          end else if (req_valid && req_ready) begin
            wr_r <= req_write; loc_r <= req_local; addr_r <= req_addr; wd_r <= req_wdata;
            st <= mode_q ? S_LOOK : S_SP;
          end
        S_SP: begin
          rsp_err <= sp_err; rsp_hit <= 1'b0; rsp_v_q <= 1'b1; st <= S_IDLE;
          rsp_rdata <= sp_err ? '0 : data_q[sp_idx][wsel*DW +: DW];
          if (!sp_err && wr_r) data_q[sp_idx][wsel*DW +: DW] <= wd_r;
        end
        S_LOOK:
          if (hit) begin
            idx_r <= {set_r, hway}; hit_r <= 1'b1; st <= S_ACC;
          end else begin
            idx_r <= vic; hit_r <= 1'b0;
            st <= (vld_q[vic] && dty_q[vic]) ? S_WB : S_FILL;
          end
        S_WB:
          if (mem_rsp_valid) begin dty_q[idx_r] <= 1'b0; st <= S_FILL; end
        S_FILL:
          if (mem_rsp_valid) begin
            data_q[idx_r] <= mem_rsp_rdata; tag_q[idx_r] <= tag_r;
            vld_q[idx_r] <= 1'b1; dty_q[idx_r] <= 1'b0;
            rr_q[set_r] <= rr_q[set_r] + 1'b1;
            st <= S_ACC;
          end
        S_ACC: begin
          rsp_rdata <= data_q[idx_r][wsel*DW +: DW];
          rsp_hit <= hit_r; rsp_err <= 1'b0;
          if (wr_r) data_q[idx_r][wsel*DW +: DW] <= wd_r;
          if (wr_r && loc_r) dty_q[idx_r] <= 1'b1;
          if (wr_r && !loc_r) st <= S_WT;
          else begin st <= S_IDLE; rsp_v_q <= 1'b1; end
        end
        S_WT:
          if (mem_rsp_valid) begin st <= S_IDLE; rsp_v_q <= 1'b1; end
        S_FLS:
          if (!ln_dty || mem_rsp_valid) begin
            dty_q[idx_r] <= 1'b0;
            if (idx_r == IDX_W'(LINES - 1)) begin
              vld_q <= '0; mode_q <= 1'b0; st <= S_IDLE;
            end else idx_r <= idx_r + 1'b1;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic outst;
  always_ff @(posedge clk)
    if (!rst_n) outst <= 1'b0;
    else if (req_valid && req_ready) outst <= 1'b1;
    else if (rsp_v_q) outst <= 1'b0;

  assert_single_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !outst);
  assert_rsp_owed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> outst);
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));
  assert_wb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FILL) |-> !ln_dty);
  assert_dirty_local_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((dty_q & ~$past(dty_q)) != '0) |-> $past(st == S_ACC && wr_r && loc_r));
  assert_sp_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> !mem_req_valid);
  assert_sp_no_tags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (vld_q == '0));
endmodule

// File: tb/test_flex_store.sv
module test_flex_store;
  logic clk = 1'b0, rst_n = 1'b0, cache_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_local = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_err;
  logic [31:0] rsp_rdata;
  logic mem_req_valid, mem_req_write;
  logic [8:0] mem_req_addr;
  logic [63:0] mem_req_wdata, mem_rsp_rdata;
  logic mem_rsp_valid;

  always #2 clk = ~clk;

  flex_store #(.ADDR_W(12), .OFF_W(3), .SET_W(2), .WAYS(2), .SP_LINES(6), .DW(32)) i_flex_store (
    .clk, .rst_n, .cache_en, .req_valid, .req_ready, .req_write, .req_local, .req_addr,
    .req_wdata, .rsp_valid, .rsp_rdata, .rsp_hit, .rsp_err, .mem_req_valid, .mem_req_write,
    .mem_req_addr, .mem_req_wdata, .mem_rsp_valid, .mem_rsp_rdata);

  int nchk = 0, nfail = 0, op_n = 0;
  logic [31:0] mem_w [1024];
  logic [31:0] gold [1024];
  logic [31:0] mexp [1024];
  logic [31:0] spm [12];
  logic        log_wr [64];
  logic [8:0]  log_ln [64];
  logic [8:0]  mtag [4][2];
  logic        mvld [4][2];
  logic        mdty [4][2];
  int          mrr [4];
  logic        cmode = 1'b1;

  function automatic logic [31:0] init_w(int w);
    return 32'h5A00_0000 ^ (w * 32'h0001_0101);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int cnt = 0;
  logic [8:0] held;
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      cnt <= 0;
      for (int i = 0; i < 1024; i++) mem_w[i] <= init_w(i);
    end else if (mem_req_valid && !mem_rsp_valid) begin
      if (cnt != 0) chk(mem_req_addr == held, "R11", 64'(mem_req_addr), 64'(held));
      held <= mem_req_addr;
      if (cnt == 2) begin
        cnt <= 0;
        mem_rsp_valid <= 1'b1;
        if (mem_req_write) begin
          mem_w[{mem_req_addr, 1'b0}] <= mem_req_wdata[31:0];
          mem_w[{mem_req_addr, 1'b1}] <= mem_req_wdata[63:32];
        end else mem_rsp_rdata <= {mem_w[{mem_req_addr, 1'b1}], mem_w[{mem_req_addr, 1'b0}]};
        log_wr[op_n % 64] <= mem_req_write;
        log_ln[op_n % 64] <= mem_req_addr;
        op_n <= op_n + 1;
      end else cnt <= cnt + 1;
    end
  end

  task automatic access(input logic wr, input logic loc, input logic [11:0] a, input logic [31:0] d);
    logic [8:0] ln = a[11:3];
    int w = int'(a[11:2]);
    int set = int'(a[4:3]);
    int way = 0;
    bit ehit = 0, ewb = 0, eerr = 0, busy_bad = 0;
    logic [8:0] wbl = '0;
    logic [31:0] erd;
    int start = op_n;
    if (cmode) begin
      for (int k = 0; k < 2; k++) if (mvld[set][k] && mtag[set][k] == ln) begin ehit = 1; way = k; end
      if (!ehit) begin
        way = mrr[set];
        if (mvld[set][way] && mdty[set][way]) begin
          ewb = 1; wbl = mtag[set][way];
          mexp[{wbl, 1'b0}] = gold[{wbl, 1'b0}];
          mexp[{wbl, 1'b1}] = gold[{wbl, 1'b1}];
        end
        mtag[set][way] = ln; mvld[set][way] = 1; mdty[set][way] = 0;
        mrr[set] = mrr[set] ^ 1;
      end
      erd = gold[w];
      if (wr) begin
        gold[w] = d;
        if (loc) mdty[set][way] = 1;
        else begin mexp[{ln, 1'b0}] = gold[{ln, 1'b0}]; mexp[{ln, 1'b1}] = gold[{ln, 1'b1}]; end
      end
    end else begin
      eerr = (ln >= 6) || (a[1:0] != 0);
      erd = eerr ? 32'h0 : spm[w];
      if (!eerr && wr) spm[w] = d;
    end
    @(negedge clk);
    req_valid = 1; req_write = wr; req_local = loc; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
    end
    chk(!busy_bad && !req_ready, "R10", 64'(busy_bad), 64'h0);
    if (!wr) chk(rsp_rdata == erd, cmode ? "R6" : "R8", 64'(rsp_rdata), 64'(erd));
    if (cmode) begin
      chk(rsp_hit == ehit, ehit ? "R1" : "R2", 64'(rsp_hit), 64'(ehit));
      if (ehit && !(wr && !loc)) chk(op_n == start, "R1", 64'(op_n - start), 64'h0);
      if (ewb) begin
        chk(log_wr[start % 64] && log_ln[start % 64] == wbl, "R5", 64'(log_ln[start % 64]), 64'(wbl));
        chk(!log_wr[(start + 1) % 64] && log_ln[(start + 1) % 64] == ln, "R5",
            64'(log_ln[(start + 1) % 64]), 64'(ln));
        chk(mem_w[{wbl, 1'b0}] == mexp[{wbl, 1'b0}] && mem_w[{wbl, 1'b1}] == mexp[{wbl, 1'b1}],
            "R4", 64'(mem_w[{wbl, 1'b0}]), 64'(mexp[{wbl, 1'b0}]));
      end
      if (wr && !loc) chk(mem_w[w] == d, "R3", 64'(mem_w[w]), 64'(d));
      if (wr && loc) chk(mem_w[w] == mexp[w], "R4", 64'(mem_w[w]), 64'(mexp[w]));
    end else begin
      chk(rsp_err == eerr, "R9", 64'(rsp_err), 64'(eerr));
      chk(op_n == start, "R8", 64'(op_n - start), 64'h0);
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    cache_en = m;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cmode = m;
    for (int s = 0; s < 4; s++) for (int k = 0; k < 2; k++) mvld[s][k] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin gold[i] = init_w(i); mexp[i] = init_w(i); end
    for (int s = 0; s < 4; s++) begin
      mrr[s] = 0;
      for (int k = 0; k < 2; k++) begin mvld[s][k] = 0; mdty[s][k] = 0; mtag[s][k] = '0; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R10", 64'(req_ready), 64'h1);
    chk(rsp_valid == 0, "R10", 64'(rsp_valid), 64'h0);
    chk(mem_req_valid == 0, "R10", 64'(mem_req_valid), 64'h0);
    for (int rep = 0; rep < 2; rep++)
      for (int l = 0; l < 16; l++)
        for (int k = 0; k < 2; k++) access(0, 0, 12'(l * 8 + k * 4), 0);
    for (int l = 16; l < 24; l++) access(1, 1, 12'(l * 8), 32'hC0DE_0000 + l);
    for (int l = 16; l < 24; l++) access(0, 0, 12'(l * 8), 0);
    for (int l = 0; l < 16; l++) access(0, 0, 12'(l * 8 + 4), 0);
    for (int l = 24; l < 32; l++) access(1, 0, 12'(l * 8 + 4), 32'hBEEF_0000 + l);
    for (int l = 24; l < 32; l++) access(1, 1, 12'(l * 8), 32'h7777_0000 + l);
    for (int l = 40; l < 44; l++) access(1, 1, 12'(l * 8 + 4), 32'h4242_0000 + l);
    set_mode(0);
    for (int i = 0; i < 1024; i++) chk(mem_w[i] == gold[i], "R7", 64'(mem_w[i]), 64'(gold[i]));
    for (int i = 0; i < 12; i++) access(1, 0, 12'(i * 4), 32'h5C00_0000 + i);
    for (int i = 11; i >= 0; i--) access(0, 0, 12'(i * 4), 0);
    access(0, 0, 12'd48, 0);
    access(1, 0, 12'd52, 32'hDEAD_0001);
    access(0, 0, 12'd60, 0);
    access(1, 0, 12'h800, 32'hDEAD_0002);
    access(0, 0, 12'd6, 0);
    access(1, 1, 12'd9, 32'hDEAD_0003);
    access(0, 0, 12'd4, 0);
    access(0, 0, 12'd8, 0);
    for (int i = 0; i < 1024; i++) chk(mem_w[i] == gold[i], "R8", 64'(mem_w[i]), 64'(gold[i]));
    set_mode(1);
    access(0, 0, 12'd0, 0);
    access(0, 0, 12'd4, 0);
    for (int l = 1; l < 3; l++) access(0, 0, 12'(l * 32), 0);
    access(0, 0, 12'd0, 0);
    access(1, 1, 12'd0, 32'h1234_5678);
    for (int l = 1; l < 3; l++) access(0, 0, 12'(l * 32 + 4), 0);
    access(0, 0, 12'd0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule